// File: doc/BRIEF.md
# Bus-Master DMA Register Block

This block is the host-facing register set of a single-channel bus-master disk DMA controller. Software programs a descriptor-table base pointer and writes a command byte. The command byte holds a go bit and a transfer direction. The block turns changes of the go bit into one-cycle start and cancel strobes for a separate descriptor engine. On every start it reloads that engine's descriptor walk pointer from the table base. The engine reports back whether a transfer has ended or still has data to move, and it can flag an error. The block keeps all of this in an 8-bit status byte.

A device interrupt input is captured into a sticky status flag on its rising edge and is forwarded to the host interrupt line. A falling edge reaches the host line without touching the status byte. Host accesses are 1, 2 or 4 bytes wide, encoded on `host_size` as 0, 1 and 2; code 3 behaves as 4 bytes. Read data is combinational from the current address and size. Written data is right-aligned on `host_wdata`.

Top module: `dmr_top`

## Requirements
- R1: The command byte sits at offset 0. A write keeps only bit 0 (go) and bit 3 (direction), so the stored value is the written byte AND 0x09, and every other bit reads back as 0.
- R2: A command write whose go bit equals the stored go bit raises neither `eng_start` nor `eng_cancel`, but the stored byte still takes the new value.
- R3: A command write that changes go from 1 to 0 raises `eng_cancel` for exactly the one cycle after the write edge and clears status bit 0 (active).
- R4: A command write that changes go from 0 to 1 copies the table base into `eng_desc_ptr`. If status bit 0 was clear, it also sets that bit and raises `eng_start` for one cycle. If the bit was already set, no start strobe is issued.
- R5: The table base occupies offsets 4 to 7, where address bit 2 selects it and bits 1:0 give the byte offset. A write replaces only the addressed byte lanes, so lanes past byte 3 are dropped. Base bits 1:0 always stay 0.
- R6: A base read returns the base shifted right by 8 times the byte offset and masked to the access width. Offsets 1 and 3 read as 0.
- R7: A rising edge on `dev_irq` sets status bit 2. `host_irq` follows `dev_irq` one cycle later. A falling edge lowers `host_irq` and leaves the status byte unchanged.
- R8: The status byte sits at offset 2. Writing 1 clears bits 1 and 2, and writing 0 leaves them alone. Bit 0 cannot be written by the host. Bits 5 and 6 are plain read/write, and all other bits read 0. A flag that is set in the same cycle as a clear ends up set.
- R9: A pulse on `eng_report` sets status bit 0 when `eng_more` is 1 and clears it when `eng_more` is 0. A command write in the same cycle overrides the report's effect on bit 0.
- R10: Reset clears the command, status, base and walk pointer to 0. `eng_cancel` is held high while reset is asserted.
- R11: `eng_to_mem` equals the stored command bit 3 as a level.
- R12: A pulse on `eng_err` sets status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the current address |
| host_addr | input | 3 | Register byte address (0 command, 2 status, 4-7 base) |
| host_size | input | 2 | Access width: 0 byte, 1 half-word, 2 or 3 word |
| host_wdata | input | 32 | Right-aligned write data |
| host_rdata | output | 32 | Right-aligned read data |
| dev_irq | input | 1 | Interrupt level from the drive side |
| host_irq | output | 1 | Interrupt level to the host |
| eng_report | input | 1 | Engine activity report strobe |
| eng_more | input | 1 | With the report: 1 if more data remains, 0 if the transfer ended |
| eng_err | input | 1 | Engine error strobe |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_cancel | output | 1 | One-cycle cancel strobe, held high during reset |
| eng_to_mem | output | 1 | Direction level: 1 means the device writes to memory |
| eng_desc_ptr | output | 32 | Descriptor walk pointer, reloaded from the base on start |

## Verification
Two kinds of event can collide in one cycle. In the first, a host command write and an engine activity report both try to change the active bit. In the second, a host write-one-to-clear of the interrupt flag lands on the same clock as a new `dev_irq` rising edge. The bench drives each pair on the same edge. It judges the command write against the host-wins rule and the clear against the set-wins rule, reading the status byte on the following cycle. It also checks that a start issued while the engine has already marked itself active reloads the pointer without a start strobe.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    // register byte offsets inside the non-base half of the map
    localparam int OFS_CMD  = 0;
    localparam int OFS_STAT = 2;

    // command bits
    localparam int          CMD_GO   = 0;
    localparam int          CMD_DIR  = 3;
    localparam logic [7:0]  CMD_KEEP = 8'h09;

    // status bits
    localparam int          ST_ACT     = 0;
    localparam int          ST_ERR     = 1;
    localparam int          ST_INT     = 2;
    localparam logic [7:0]  ST_RW_MASK = 8'h60;
    localparam logic [7:0]  ST_W1C_MASK = 8'h06;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] stat;
        logic       start;
        logic       abort;
        logic       irq_seen;
    } ctl_t;

endpackage

// File: rtl/dmr_base_reg.sv
module dmr_base_reg
    import dmr_pkg::*;
#(
    parameter int PTR_W = 32,
    localparam int NBYTES = PTR_W / 8,
    localparam int LANE_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane_off,
    input  logic [1:0]        size,
    input  logic [PTR_W-1:0]  wdata,
    output logic [PTR_W-1:0]  base_o
);

    logic [PTR_W-1:0]  base_d, base_q;
    logic [PTR_W-1:0]  wdata_sh;
    logic [NBYTES-1:0] lane_hit;
    int                nbytes;

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            default: nbytes = NBYTES;
        endcase
    end

    assign wdata_sh = wdata << {lane_off, 3'b000};

    // one select per byte lane: inside [offset, offset + width)
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_hit[b] = wr_en && (b >= int'(lane_off)) && (b < int'(lane_off) + nbytes);
        always_comb begin
            base_d[b*8 +: 8] = lane_hit[b] ? wdata_sh[b*8 +: 8] : base_q[b*8 +: 8];
            if (b == 0) begin
                base_d[1:0] = 2'b00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base_o = base_q;

    p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        base_o[1:0] == 2'b00);

    p_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> base_o == $past(base_o));

endmodule

// File: rtl/dmr_ctl.sv
module dmr_ctl
    import dmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       stat_we,
    input  logic [7:0] wbyte,
    input  logic       eng_report,
    input  logic       eng_more,
    input  logic       eng_err,
    input  logic       dev_irq,
    output logic [7:0] cmd_o,
    output logic [7:0] stat_o,
    output logic       start_o,
    output logic       abort_o,
    output logic       reload_o,
    output logic       host_irq_o
);

    ctl_t d, q;

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.abort    = 1'b0;
        d.irq_seen = dev_irq;

        // engine report on the active bit
        if (eng_report) begin
            d.stat[ST_ACT] = eng_more;
        end

        // host status write: plain bits replaced, sticky bits cleared by ones
        if (stat_we) begin
            d.stat = (d.stat & ~ST_RW_MASK) | (wbyte & ST_RW_MASK);
            d.stat = d.stat & ~(wbyte & ST_W1C_MASK);
        end

        // set sources win over a clear in the same cycle
        if (eng_err) begin
            d.stat[ST_ERR] = 1'b1;
        end
        if (dev_irq && !q.irq_seen) begin
            d.stat[ST_INT] = 1'b1;
        end

        // command write: act on a go-bit change only; host wins over report
        if (cmd_we) begin
            if (wbyte[CMD_GO] != q.cmd[CMD_GO]) begin
                if (!wbyte[CMD_GO]) begin
                    d.abort        = 1'b1;
                    d.stat[ST_ACT] = 1'b0;
                end else if (!q.stat[ST_ACT]) begin
                    d.stat[ST_ACT] = 1'b1;
                    d.start        = 1'b1;
                end else begin
                    d.stat[ST_ACT] = 1'b1;
                end
            end
            d.cmd = wbyte & CMD_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_o      = q.cmd;
    assign stat_o     = q.stat;
    assign start_o    = q.start;
    assign abort_o    = q.abort | ~rst_n;
    assign reload_o   = cmd_we && wbyte[CMD_GO] && !q.cmd[CMD_GO];
    assign host_irq_o = q.irq_seen;

    p_cmd_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> cmd_o == ($past(wbyte) & 8'h09));

    p_same_go_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (wbyte[CMD_GO] == cmd_o[CMD_GO])) |=> (!start_o && !q.abort));

    p_cancel_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.abort |-> !stat_o[ST_ACT]);

    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    p_irq_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq && !host_irq_o) |=> (stat_o[ST_INT] && host_irq_o));

    p_act_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !cmd_we && !eng_report) |=> stat_o[ST_ACT] == $past(stat_o[ST_ACT]));

    p_err_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> stat_o[ST_ERR]);

endmodule

// File: rtl/dmr_top.sv
module dmr_top
    import dmr_pkg::*;
#(
    parameter int PTR_W = 32,
    localparam int NBYTES = PTR_W / 8,
    localparam int LANE_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [LANE_W:0]   host_addr,
    input  logic [1:0]        host_size,
    input  logic [PTR_W-1:0]  host_wdata,
    output logic [PTR_W-1:0]  host_rdata,
    input  logic              dev_irq,
    output logic              host_irq,
    input  logic              eng_report,
    input  logic              eng_more,
    input  logic              eng_err,
    output logic              eng_start,
    output logic              eng_cancel,
    output logic              eng_to_mem,
    output logic [PTR_W-1:0]  eng_desc_ptr
);

    localparam logic [LANE_W-1:0] OFS_CMD_L  = LANE_W'(OFS_CMD);
    localparam logic [LANE_W-1:0] OFS_STAT_L = LANE_W'(OFS_STAT);

    logic              base_sel;
    logic [LANE_W-1:0] lane_off;
    logic              cmd_we, stat_we, base_we, reload;
    logic [7:0]        cmd_v, stat_v;
    logic [PTR_W-1:0]  base_v;
    logic [PTR_W-1:0]  cur_d, cur_q;
    logic [PTR_W-1:0]  width_mask;

    assign base_sel = host_addr[LANE_W];
    assign lane_off = host_addr[LANE_W-1:0];
    assign base_we  = host_wr && base_sel;
    assign cmd_we   = host_wr && !base_sel && (lane_off == OFS_CMD_L);
    assign stat_we  = host_wr && !base_sel && (lane_off == OFS_STAT_L);

    dmr_base_reg #(.PTR_W(PTR_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (base_we),
        .lane_off (lane_off),
        .size     (host_size),
        .wdata    (host_wdata),
        .base_o   (base_v)
    );

    dmr_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .stat_we    (stat_we),
        .wbyte      (host_wdata[7:0]),
        .eng_report (eng_report),
        .eng_more   (eng_more),
        .eng_err    (eng_err),
        .dev_irq    (dev_irq),
        .cmd_o      (cmd_v),
        .stat_o     (stat_v),
        .start_o    (eng_start),
        .abort_o    (eng_cancel),
        .reload_o   (reload),
        .host_irq_o (host_irq)
    );

    // walk pointer: reloaded from the base on every go 0->1
    always_comb begin
        cur_d = reload ? base_v : cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign eng_desc_ptr = cur_q;
    assign eng_to_mem   = cmd_v[CMD_DIR];

    // read path
    always_comb begin
        case (acc_size_e'(host_size))
            SZ_BYTE: width_mask = PTR_W'(8'hFF);
            SZ_HALF: width_mask = PTR_W'(16'hFFFF);
            default: width_mask = '1;
        endcase
    end

    always_comb begin
        host_rdata = '0;
        if (base_sel) begin
            host_rdata = (base_v >> {lane_off, 3'b000}) & width_mask;
        end else if (lane_off == OFS_CMD_L) begin
            host_rdata = PTR_W'(cmd_v);
        end else if (lane_off == OFS_STAT_L) begin
            host_rdata = PTR_W'(stat_v);
        end
    end

    p_reload_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> eng_desc_ptr == $past(base_v));

    p_dir_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> eng_to_mem == $past(host_wdata[3]));

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_irq) |=> (!host_irq && stat_v[2] == $past(stat_v[2])) || eng_err || eng_report || host_wr);

endmodule

// File: tb/dmr_top_tb.sv
module dmr_top_tb;

    localparam int K_RDATA = 0;
    localparam int K_START = 1;
    localparam int K_ABORT = 2;
    localparam int K_DIR   = 3;
    localparam int K_IRQ   = 4;
    localparam int K_PTR   = 5;

    typedef struct {
        int          kind;
        string       req;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dev_irq = 1'b0;
    logic        host_irq;
    logic        eng_report = 1'b0;
    logic        eng_more = 1'b0;
    logic        eng_err = 1'b0;
    logic        eng_start;
    logic        eng_cancel;
    logic        eng_to_mem;
    logic [31:0] eng_desc_ptr;

    item_t q_exp[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    dmr_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_size    (host_size),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .dev_irq      (dev_irq),
        .host_irq     (host_irq),
        .eng_report   (eng_report),
        .eng_more     (eng_more),
        .eng_err      (eng_err),
        .eng_start    (eng_start),
        .eng_cancel   (eng_cancel),
        .eng_to_mem   (eng_to_mem),
        .eng_desc_ptr (eng_desc_ptr)
    );

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = q_exp.pop_front();
            case (it.kind)
                K_RDATA: act = host_rdata;
                K_START: act = {31'd0, eng_start};
                K_ABORT: act = {31'd0, eng_cancel};
                K_DIR:   act = {31'd0, eng_to_mem};
                K_IRQ:   act = {31'd0, host_irq};
                default: act = eng_desc_ptr;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic expect_v(input int kind, input string req, input logic [31:0] e);
        item_t it;
        it.kind = kind;
        it.req  = req;
        it.exp  = e;
        q_exp.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_size = sz; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] e, input string req);
        host_addr = a; host_size = sz;
        expect_v(K_RDATA, req, e);
        @(posedge clk); #1;
    endtask

    task automatic eng_pulse(input logic more);
        @(posedge clk); #1;
        eng_report = 1'b1; eng_more = more;
        @(posedge clk); #1;
        eng_report = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        #2;
        expect_v(K_ABORT, "R10 cancel during reset", 32'd1);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd(3'd0, 2'd0, 32'h0, "R10 cmd after reset");
        rd(3'd2, 2'd0, 32'h0, "R10 status after reset");
        expect_v(K_PTR, "R10 pointer after reset", 32'h0);
        expect_v(K_START, "R10 no start after reset", 32'd0);
        expect_v(K_IRQ, "R10 host irq low", 32'd0);
        rd(3'd4, 2'd2, 32'h0, "R10 base after reset");

        // R5 / R6 base lanes, alignment and read shaping
        wr(3'd4, 2'd2, 32'h1234_5677);
        rd(3'd4, 2'd2, 32'h1234_5674, "R5 word write low bits forced");
        wr(3'd6, 2'd1, 32'h0000_ABCD);
        rd(3'd4, 2'd2, 32'hABCD_5674, "R5 half write upper lanes");
        wr(3'd5, 2'd0, 32'h0000_00EF);
        rd(3'd4, 2'd2, 32'hABCD_EF74, "R5 byte write lane 1");
        wr(3'd4, 2'd0, 32'h0000_00FF);
        rd(3'd4, 2'd2, 32'hABCD_EFFC, "R5 byte lane 0 alignment");
        wr(3'd6, 2'd2, 32'h5555_ABCD);
        rd(3'd4, 2'd2, 32'hABCD_EFFC, "R5 lanes past byte 3 dropped");
        rd(3'd7, 2'd0, 32'h0000_00AB, "R6 byte read offset 3");
        rd(3'd5, 2'd1, 32'h0000_CDEF, "R6 half read offset 1");
        rd(3'd6, 2'd2, 32'h0000_ABCD, "R6 word read offset 2");
        rd(3'd1, 2'd0, 32'h0, "R6 unmapped offset reads zero");

        // R1 / R2 / R11 command without go change
        wr(3'd0, 2'd0, 32'h0000_00F6);
        expect_v(K_START, "R2 no start on 0->0", 32'd0);
        expect_v(K_ABORT, "R2 no cancel on 0->0", 32'd0);
        rd(3'd0, 2'd0, 32'h0, "R1 cmd masked to zero");
        wr(3'd0, 2'd0, 32'h0000_00FE);
        expect_v(K_START, "R2 no start with dir set", 32'd0);
        expect_v(K_DIR, "R11 direction high", 32'd1);
        rd(3'd0, 2'd0, 32'h08, "R1 cmd keeps bit 3");

        // R4 start
        wr(3'd0, 2'd0, 32'h0000_0009);
        expect_v(K_START, "R4 start strobe", 32'd1);
        expect_v(K_PTR, "R4 pointer reload", 32'hABCD_EFFC);
        expect_v(K_DIR, "R11 direction still high", 32'd1);
        rd(3'd0, 2'd0, 32'h09, "R1 cmd go and dir");
        expect_v(K_START, "R4 start lasts one cycle", 32'd0);
        rd(3'd2, 2'd0, 32'h01, "R4 active set");

        // R2 same go, value updated
        wr(3'd0, 2'd0, 32'h0000_0001);
        expect_v(K_START, "R2 no start on 1->1", 32'd0);
        expect_v(K_ABORT, "R2 no cancel on 1->1", 32'd0);
        expect_v(K_DIR, "R11 direction low", 32'd0);
        rd(3'd0, 2'd0, 32'h01, "R2 cmd updated");

        // R3 stop
        wr(3'd0, 2'd0, 32'h0);
        expect_v(K_ABORT, "R3 cancel strobe", 32'd1);
        rd(3'd2, 2'd0, 32'h00, "R3 active cleared");
        expect_v(K_ABORT, "R3 cancel lasts one cycle", 32'd0);
        rd(3'd0, 2'd0, 32'h00, "R3 cmd zero");

        // R9 engine reports and start with active already set
        eng_pulse(1'b1);
        rd(3'd2, 2'd0, 32'h01, "R9 more sets active");
        wr(3'd4, 2'd2, 32'h0000_0100);
        wr(3'd0, 2'd0, 32'h0000_0001);
        expect_v(K_START, "R4 no start while active", 32'd0);
        expect_v(K_PTR, "R4 reload while active", 32'h0000_0100);
        rd(3'd2, 2'd0, 32'h01, "R4 active kept");
        eng_pulse(1'b0);
        rd(3'd2, 2'd0, 32'h00, "R9 ended clears active");
        wr(3'd0, 2'd0, 32'h0);
        expect_v(K_ABORT, "R3 cancel after end", 32'd1);
        wr(3'd0, 2'd0, 32'h0000_0001);
        expect_v(K_START, "R4 start from idle", 32'd1);
        // same cycle: stop command and a more report
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = 3'd0; host_size = 2'd0; host_wdata = 32'h0;
        eng_report = 1'b1; eng_more = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; eng_report = 1'b0;
        expect_v(K_ABORT, "R9 stop with report cancels", 32'd1);
        rd(3'd2, 2'd0, 32'h00, "R9 host command wins");

        // R7 interrupt capture and pass-through
        @(posedge clk); #1 dev_irq = 1'b1;
        @(posedge clk); #1;
        expect_v(K_IRQ, "R7 host irq rises", 32'd1);
        rd(3'd2, 2'd0, 32'h04, "R7 interrupt flag set");
        dev_irq = 1'b0;
        @(posedge clk); #1;
        expect_v(K_IRQ, "R7 host irq falls", 32'd0);
        rd(3'd2, 2'd0, 32'h04, "R7 flag kept on fall");
        wr(3'd2, 2'd0, 32'h0000_0004);
        rd(3'd2, 2'd0, 32'h00, "R8 interrupt cleared by one");
        // set flag again, then clear together with a new rising edge
        @(posedge clk); #1 dev_irq = 1'b1;
        @(posedge clk); #1 dev_irq = 1'b0;
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = 3'd2; host_size = 2'd0; host_wdata = 32'h04;
        dev_irq = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
        rd(3'd2, 2'd0, 32'h04, "R8 set wins over clear");
        dev_irq = 1'b0;
        wr(3'd2, 2'd0, 32'h0000_0004);
        rd(3'd2, 2'd0, 32'h00, "R8 flag cleared");

        // R8 plain bits and read-only active; R12 error
        wr(3'd2, 2'd0, 32'h0000_00FF);
        rd(3'd2, 2'd0, 32'h60, "R8 only bits 5 and 6 stored");
        @(posedge clk); #1 eng_err = 1'b1;
        @(posedge clk); #1 eng_err = 1'b0;
        rd(3'd2, 2'd0, 32'h62, "R12 error flag set");
        wr(3'd2, 2'd0, 32'h0000_0062);
        rd(3'd2, 2'd0, 32'h60, "R8 error cleared, plain bits kept");
        wr(3'd2, 2'd0, 32'h0000_0000);
        rd(3'd2, 2'd0, 32'h00, "R8 plain bits written zero");

        // R10 reset in the middle of activity
        wr(3'd4, 2'd2, 32'h0000_4000);
        wr(3'd0, 2'd0, 32'h0000_0009);
        @(posedge clk); #1 rst_n = 1'b0;
        expect_v(K_ABORT, "R10 cancel held in reset", 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        expect_v(K_PTR, "R10 pointer cleared", 32'h0);
        expect_v(K_DIR, "R10 direction cleared", 32'd0);
        rd(3'd0, 2'd0, 32'h00, "R10 cmd cleared");
        rd(3'd2, 2'd0, 32'h00, "R10 status cleared");
        rd(3'd4, 2'd2, 32'h00, "R10 base cleared");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule